// File: doc/BRIEF.md
# Programmable Chip-Select Channel

This block is one chip-select channel for a 24-bit, 16-bit-data bus. Two configuration words program it. The base word holds the upper address bits of a memory block and a block-size code. The option word holds the access conditions and the bus-cycle termination. When a bus cycle falls inside the programmed block and meets every condition, the channel drives an active-low select. The select is timed from either the synchronised address strobe or the synchronised data strobe. The channel then terminates the cycle itself, either after a programmed number of wait states or at once, or it leaves termination to the addressed device.

A 2-bit pin-mode input assigns the select pin:

- **Chip select.** The channel drives the pin as a select for an 8-bit or a 16-bit port. The port width decides which lanes of the 2-bit acknowledge are driven.
- **Alternate function.** The pin is released.
- **Discrete output.** The pin follows a data bit.

Bus strobes pass through a two-stage synchroniser before the decode. Address, function code and direction are taken to be stable while the address strobe is low.

Top module: `csel_channel`

## Requirements
- R1: After reset, with pin mode 11, selN is 1, ackN is 2'b11 and avecN is 1.
- R2: The base word is split as follows: bits 15:3 hold address bits 23:11 and bits 2:0 hold the block-size code. Codes 0 to 7 give 2K, 8K, 16K, 64K, 128K, 256K, 512K and 1M bytes. A non-CPU-space cycle matches only when the address bits above the block size equal the corresponding base bits.
- R3: The option word is 15 bits wide, and its bits 5:4 give the address space. 01 accepts user cycles (function code 1 or 2), 10 accepts supervisor cycles (5 or 6) and 11 accepts either. 00 accepts CPU-space cycles (function code 7) with address bits 19:16 equal to 4'hF. Such a cycle also needs option bits 3:1 equal to 0, or equal to address bits 3:1. CPU-space cycles skip the block compare.
- R4: Option bits 12:11 give the direction. 01 matches reads only (rdWr=1), 10 matches writes only (rdWr=0), 11 matches both and 00 matches nothing.
- R5: Option bits 14:13 give the byte lanes. 00 never matches. When the data strobe is chosen, 01 needs ldsN low, 10 needs udsN low and 11 needs either one.
- R6: With option bit 10 = 0 (address-strobe timing), selN falls at the 3rd rising edge after asN falls. It rises at the 3rd rising edge after asN rises.
- R7: With option bit 10 = 1 (data-strobe timing), selN falls at the 3rd rising edge after a needed lane strobe falls while asN is low.
- R8: For termination code c = 0 to 13 in option bits 9:6, the acknowledge is asserted at rising edge 4+c after the strobe that starts the select. It is released together with the select.
- R9: Termination code 14 asserts the acknowledge at the same edge as the select.
- R10: Termination code 15 never asserts ackN or avecN. The select stays low until the address strobe is released.
- R11: Pin mode 11 (16-bit port) drives ackN as 2'b00 when acknowledging. Pin mode 10 (8-bit port) drives 2'b10.
- R12: Pin mode 00 makes selN follow discreteBit, and pin mode 01 holds selN at 1. In both modes the decode is ignored, and ackN stays 2'b11 and avecN stays 1.
- R13: In a CPU-space cycle with option bit 0 set, the termination is signalled by avecN low instead of ackN, and ackN stays 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinMode | input | 2 | Pin assignment: 00 discrete, 01 alternate, 10 select for an 8-bit port, 11 select for a 16-bit port |
| discreteBit | input | 1 | Pin value in discrete mode |
| baseReg | input | 16 | Base word: upper address bits and block-size code |
| optReg | input | 15 | Option word: lanes, direction, strobe, termination, space, level, autovector |
| busAddr | input | 24 | Bus address |
| funcCode | input | 3 | Bus function code |
| rdWr | input | 1 | 1 for read, 0 for write |
| asN | input | 1 | Address strobe, active low |
| udsN | input | 1 | Upper-lane data strobe, active low |
| ldsN | input | 1 | Lower-lane data strobe, active low |
| selN | output | 1 | Select pin, active low |
| ackN | output | 2 | Cycle acknowledge per lane, active low |
| avecN | output | 1 | Autovector request, active low |

## Verification
The assertions take the following for granted:
- Configuration words and pin mode change only while the address strobe is high.
- Address, function code and direction are held for the whole strobe-low period.
- Each strobe-low period lasts longer than the programmed wait count.

The stimulus meets these conditions in the following way. The bench programs the channel between cycles and sets the address before lowering asN. It holds every cycle for 24 edges, longer than the 17-edge worst case, and then leaves a gap of several idle edges.

// File: rtl/csel_pkg.sv
package csel_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_TERM = 2'd2,
    ST_EXT  = 2'd3
  } cselState_t;

  typedef struct packed {
    logic loadCnt;
    logic decCnt;
    logic selOn;
    logic ackOn;
  } cselCtl_t;

  localparam logic [3:0] TERM_FAST = 4'd14;
  localparam logic [3:0] TERM_EXT  = 4'd15;

  function automatic int unsigned blockShift(input logic [2:0] code);
    case (code)
      3'd0: return 11;
      3'd1: return 13;
      3'd2: return 14;
      3'd3: return 16;
      3'd4: return 17;
      3'd5: return 18;
      3'd6: return 19;
      default: return 20;
    endcase
  endfunction
endpackage

// File: rtl/csel_datapath.sv
module csel_datapath
  import csel_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int BASE_LSB = 11,
  parameter int WAIT_W = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-BASE_LSB+2:0] baseReg,
  input  logic [14:0]             optReg,
  input  logic [ADDR_W-1:0]       busAddr,
  input  logic [2:0]              funcCode,
  input  logic                    rdWr,
  input  logic                    asN,
  input  logic                    udsN,
  input  logic                    ldsN,
  input  cselCtl_t                ctl,
  output logic                    cycleHit,
  output logic                    strobeOff,
  output logic                    cntZero,
  output logic [3:0]              termCode,
  output logic                    selReg,
  output logic                    ackReg
);
  localparam int CMP_W = ADDR_W - BASE_LSB;

  // strobe synchroniser: {as, uds, lds}
  logic [2:0] syncQ [SYNC_STAGES];
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncQ[i] <= 3'b111;
    end else begin
      syncQ[0] <= {asN, udsN, ldsN};
      for (int i = 1; i < SYNC_STAGES; i++) syncQ[i] <= syncQ[i-1];
    end
  end

  logic asS, udsS, ldsS;
  assign {asS, udsS, ldsS} = syncQ[SYNC_STAGES-1];

  // option fields
  logic [1:0] laneSel, dirSel, spaceSel;
  logic       dsTiming;
  logic [2:0] iplSel;
  assign laneSel  = optReg[14:13];
  assign dirSel   = optReg[12:11];
  assign dsTiming = optReg[10];
  assign termCode = optReg[9:6];
  assign spaceSel = optReg[5:4];
  assign iplSel   = optReg[3:1];

  // block address compare, one comparator per base bit
  int unsigned shiftAmt;
  assign shiftAmt = blockShift(baseReg[2:0]);

  logic [CMP_W-1:0] bitOk;
  genvar g;
  generate
    for (g = 0; g < CMP_W; g++) begin : g_cmp
      assign bitOk[g] = (busAddr[BASE_LSB+g] == baseReg[3+g]) ||
                        ((BASE_LSB + g) < shiftAmt);
    end
  endgenerate
  logic addrOk;
  assign addrOk = &bitOk;

  // space qualification
  logic isUser, isSuper, isCpu, cpuOk, spaceOk;
  assign isUser  = (funcCode == 3'd1) || (funcCode == 3'd2);
  assign isSuper = (funcCode == 3'd5) || (funcCode == 3'd6);
  assign isCpu   = (funcCode == 3'd7);
  assign cpuOk   = isCpu && (busAddr[19:16] == 4'hF) &&
                   ((iplSel == 3'd0) || (busAddr[3:1] == iplSel));
  always_comb begin
    case (spaceSel)
      2'b00:   spaceOk = cpuOk;
      2'b01:   spaceOk = isUser && addrOk;
      2'b10:   spaceOk = isSuper && addrOk;
      default: spaceOk = (isUser || isSuper) && addrOk;
    endcase
  end

  // direction qualification
  logic dirOk;
  always_comb begin
    case (dirSel)
      2'b01:   dirOk = rdWr;
      2'b10:   dirOk = !rdWr;
      2'b11:   dirOk = 1'b1;
      default: dirOk = 1'b0;
    endcase
  end

  // lane qualification
  logic laneStrobe;
  always_comb begin
    case (laneSel)
      2'b01:   laneStrobe = !ldsS;
      2'b10:   laneStrobe = !udsS;
      2'b11:   laneStrobe = !udsS || !ldsS;
      default: laneStrobe = 1'b0;
    endcase
  end

  logic laneOk;
  assign laneOk = (laneSel != 2'b00) && (!dsTiming || laneStrobe);

  assign strobeOff = asS;
  assign cycleHit  = !asS && spaceOk && dirOk && laneOk;

  // wait-state counter and registered pin strobes
  logic [WAIT_W-1:0] waitCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt <= '0;
      selReg  <= 1'b0;
      ackReg  <= 1'b0;
    end else begin
      if (ctl.loadCnt)     waitCnt <= WAIT_W'(termCode);
      else if (ctl.decCnt) waitCnt <= waitCnt - 1'b1;
      selReg <= ctl.selOn;
      ackReg <= ctl.ackOn;
    end
  end
  assign cntZero = (waitCnt == '0);
endmodule

// File: rtl/csel_control.sv
module csel_control
  import csel_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       isCs,
  input  logic       cycleHit,
  input  logic       strobeOff,
  input  logic       cntZero,
  input  logic [3:0] termCode,
  output cselCtl_t   ctl
);
  cselState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState   = state;
    ctl.loadCnt = 1'b0;
    ctl.decCnt  = 1'b0;
    if (!isCs) begin
      nextState = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cycleHit) begin
            if (termCode == TERM_FAST)     nextState = ST_TERM;
            else if (termCode == TERM_EXT) nextState = ST_EXT;
            else begin
              nextState   = ST_WAIT;
              ctl.loadCnt = 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (strobeOff)    nextState = ST_IDLE;
          else if (cntZero) nextState = ST_TERM;
          else              ctl.decCnt = 1'b1;
        end
        default: begin
          if (strobeOff) nextState = ST_IDLE;
        end
      endcase
    end
    ctl.selOn = (nextState != ST_IDLE);
    ctl.ackOn = (nextState == ST_TERM);
  end
endmodule

// File: rtl/csel_channel.sv
module csel_channel
  import csel_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int BASE_LSB = 11,
  parameter int WAIT_W = 4,
  parameter int SYNC_STAGES = 2,
  localparam int BASE_W = ADDR_W - BASE_LSB + 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        pinMode,
  input  logic              discreteBit,
  input  logic [BASE_W-1:0] baseReg,
  input  logic [14:0]       optReg,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [2:0]        funcCode,
  input  logic              rdWr,
  input  logic              asN,
  input  logic              udsN,
  input  logic              ldsN,
  output logic              selN,
  output logic [1:0]        ackN,
  output logic              avecN
);
  cselCtl_t   ctl;
  logic       cycleHit, strobeOff, cntZero, selReg, ackReg;
  logic [3:0] termCode;
  logic       isCs;

  assign isCs = pinMode[1];

  csel_datapath #(
    .ADDR_W(ADDR_W), .BASE_LSB(BASE_LSB), .WAIT_W(WAIT_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .baseReg(baseReg), .optReg(optReg),
    .busAddr(busAddr), .funcCode(funcCode), .rdWr(rdWr),
    .asN(asN), .udsN(udsN), .ldsN(ldsN), .ctl(ctl),
    .cycleHit(cycleHit), .strobeOff(strobeOff), .cntZero(cntZero),
    .termCode(termCode), .selReg(selReg), .ackReg(ackReg)
  );

  csel_control u_ctl (
    .clk(clk), .rstN(rstN), .isCs(isCs), .cycleHit(cycleHit),
    .strobeOff(strobeOff), .cntZero(cntZero), .termCode(termCode), .ctl(ctl)
  );

  logic avecMode, termActive;
  assign avecMode   = optReg[0] && (funcCode == 3'd7);
  assign termActive = ackReg && isCs;

  always_comb begin
    case (pinMode)
      2'b00:   selN = discreteBit;
      2'b01:   selN = 1'b1;
      default: selN = !selReg;
    endcase
    if (termActive && !avecMode) ackN = pinMode[0] ? 2'b00 : 2'b10;
    else                         ackN = 2'b11;
    avecN = !(termActive && avecMode);
  end
endmodule

// File: rtl/csel_channel_chk.sv
module csel_channel_chk (
  input logic        clk,
  input logic        rstN,
  input logic [1:0]  pinMode,
  input logic [14:0] optReg,
  input logic        asN,
  input logic        selN,
  input logic [1:0]  ackN,
  input logic        avecN
);
  // R11: an 8-bit port never drives the upper acknowledge lane
  a_r11_narrow_lane: assert property (@(posedge clk) disable iff (!rstN)
    (pinMode == 2'b10) |-> ackN[1]);

  // R10: external termination never acknowledges
  a_r10_ext_no_ack: assert property (@(posedge clk) disable iff (!rstN)
    (pinMode[1] && optReg[9:6] == 4'd15 && $past(optReg[9:6]) == 4'd15)
      |-> (ackN == 2'b11 && avecN));

  // R6: a falling select is preceded by a held-low address strobe
  a_r6_sel_after_strobe: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(selN) && pinMode[1] && $past(pinMode[1])) |-> ($past(asN, 2) == 1'b0));

  // R8: an acknowledge only appears while the select is low
  a_r8_ack_inside_sel: assert property (@(posedge clk) disable iff (!rstN)
    (pinMode[1] && ackN != 2'b11) |-> !selN);

  // R12: non-select pin modes never terminate cycles
  a_r12_no_term_off_mode: assert property (@(posedge clk) disable iff (!rstN)
    (!pinMode[1]) |-> (ackN == 2'b11 && avecN));

  // R13: autovector and acknowledge are exclusive
  a_r13_avec_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    (!avecN) |-> (ackN == 2'b11));
endmodule

bind csel_channel csel_channel_chk u_chk (
  .clk(clk), .rstN(rstN), .pinMode(pinMode), .optReg(optReg),
  .asN(asN), .selN(selN), .ackN(ackN), .avecN(avecN)
);

// File: tb/test_csel_channel.sv
`timescale 1ns/100ps
module test_csel_channel;
  localparam int HOLD = 24;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  pinMode = 2'b11;
  logic        discreteBit = 1'b1;
  logic [15:0] baseReg = 16'h1203;
  logic [14:0] optReg = '0;
  logic [23:0] busAddr = '0;
  logic [2:0]  funcCode = 3'd5;
  logic        rdWr = 1'b1;
  logic        asN = 1'b1, udsN = 1'b1, ldsN = 1'b1;
  logic        selN, avecN;
  logic [1:0]  ackN;

  always #2.5 clk = !clk;

  csel_channel i_csel_channel (
    .clk(clk), .rstN(rstN), .pinMode(pinMode), .discreteBit(discreteBit),
    .baseReg(baseReg), .optReg(optReg), .busAddr(busAddr), .funcCode(funcCode),
    .rdWr(rdWr), .asN(asN), .udsN(udsN), .ldsN(ldsN),
    .selN(selN), .ackN(ackN), .avecN(avecN)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct packed {
    int expSel;
    int expAck;
    logic [1:0] expAckVal;
    int expAvec;
  } item_t;
  item_t expQ[$];
  string tagQ[$];
  event cycStart, cycEnd;

  task automatic check(string tag, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  function automatic logic [14:0] mkOpt(logic [1:0] lanes, logic [1:0] dir, logic strb,
                                        logic [3:0] term, logic [1:0] space,
                                        logic [2:0] ipl, logic av);
    return {lanes, dir, strb, term, space, ipl, av};
  endfunction

  // driver: pushes the expectation, then runs one bus cycle
  task automatic busCycle(string tag, logic [23:0] addr, logic [2:0] fc, logic rd,
                          logic useUpper, logic useLower, int dsLag,
                          int expSel, int expAck, logic [1:0] expAckVal, int expAvec);
    item_t it;
    @(negedge clk);
    busAddr = addr; funcCode = fc; rdWr = rd;
    it.expSel = expSel; it.expAck = expAck; it.expAckVal = expAckVal; it.expAvec = expAvec;
    expQ.push_back(it);
    tagQ.push_back(tag);
    asN = 1'b0;
    if (dsLag == 0) begin udsN = !useUpper; ldsN = !useLower; end
    -> cycStart;
    for (int i = 1; i <= HOLD; i++) begin
      @(posedge clk);
      if (i == dsLag) begin
        @(negedge clk);
        udsN = !useUpper; ldsN = !useLower;
      end
    end
    @(negedge clk);
    asN = 1'b1; udsN = 1'b1; ldsN = 1'b1;
    -> cycEnd;
    repeat (6) @(posedge clk);
  endtask

  // monitor: measures the edge of each output event and compares
  initial begin
    forever begin
      item_t it;
      string tag;
      int selE, ackE, avecE, relE;
      logic [1:0] ackV;
      @(cycStart);
      it = expQ.pop_front();
      tag = tagQ.pop_front();
      selE = 0; ackE = 0; avecE = 0; relE = 0; ackV = 2'b11;
      for (int i = 1; i <= HOLD; i++) begin
        @(posedge clk); #1;
        if (!selN && selE == 0) selE = i;
        if (ackN != 2'b11 && ackE == 0) begin ackE = i; ackV = ackN; end
        if (!avecN && avecE == 0) avecE = i;
      end
      check({tag, " select edge"}, selE, it.expSel);
      check({tag, " ack edge"}, ackE, it.expAck);
      if (it.expAck != 0) check({tag, " ack lanes"}, int'(ackV), int'(it.expAckVal));
      check({tag, " avec edge"}, avecE, it.expAvec);
      if (it.expSel != 0) begin
        @(cycEnd);
        for (int j = 1; j <= 5; j++) begin
          @(posedge clk); #1;
          if (selN && relE == 0) begin
            relE = j;
            check({tag, " ack released with select"}, int'(ackN), 3);
          end
        end
        check({tag, " R6 release edge"}, relE, 3);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 reset selN", int'(selN), 1);
    check("R1 reset ackN", int'(ackN), 3);
    check("R1 reset avecN", int'(avecN), 1);
    rstN = 1'b1;
    repeat (2) @(posedge clk);

    // 64K block at 0x120000, supervisor/user, read+write, AS timing
    baseReg = 16'h1203;
    optReg = mkOpt(2'b11, 2'b11, 1'b0, 4'd2, 2'b11, 3'd0, 1'b0);
    busCycle("R8 two waits", 24'h123456, 3'd5, 1'b1, 1, 1, 0, 3, 6, 2'b00, 0);
    busCycle("R2 outside 64K block", 24'h130000, 3'd5, 1'b1, 1, 1, 0, 0, 0, 2'b11, 0);

    // 2K block, zero waits
    baseReg = 16'h1200;
    optReg = mkOpt(2'b11, 2'b11, 1'b0, 4'd0, 2'b11, 3'd0, 1'b0);
    busCycle("R2 inside 2K block", 24'h120400, 3'd1, 1'b0, 1, 1, 0, 3, 4, 2'b00, 0);
    busCycle("R2 above 2K block", 24'h120800, 3'd1, 1'b0, 1, 1, 0, 0, 0, 2'b11, 0);

    // R3 user-only space
    baseReg = 16'h1203;
    optReg = mkOpt(2'b11, 2'b11, 1'b0, 4'd14, 2'b01, 3'd0, 1'b0);
    busCycle("R3 supervisor refused", 24'h120010, 3'd5, 1'b1, 1, 1, 0, 0, 0, 2'b11, 0);
    busCycle("R3 user accepted R9 fast", 24'h120010, 3'd2, 1'b1, 1, 1, 0, 3, 3, 2'b00, 0);

    // R4 direction
    optReg = mkOpt(2'b11, 2'b01, 1'b0, 4'd14, 2'b11, 3'd0, 1'b0);
    busCycle("R4 write to read-only", 24'h120020, 3'd5, 1'b0, 1, 1, 0, 0, 0, 2'b11, 0);
    optReg = mkOpt(2'b11, 2'b10, 1'b0, 4'd14, 2'b11, 3'd0, 1'b0);
    busCycle("R4 write to write-only", 24'h120020, 3'd5, 1'b0, 1, 1, 0, 3, 3, 2'b00, 0);

    // R5 lanes
    optReg = mkOpt(2'b00, 2'b11, 1'b0, 4'd14, 2'b11, 3'd0, 1'b0);
    busCycle("R5 lanes disabled", 24'h120030, 3'd5, 1'b1, 1, 1, 0, 0, 0, 2'b11, 0);
    optReg = mkOpt(2'b01, 2'b11, 1'b1, 4'd14, 2'b11, 3'd0, 1'b0);
    busCycle("R5 upper strobe on lower channel", 24'h120030, 3'd5, 1'b1, 1, 0, 2, 0, 0, 2'b11, 0);
    busCycle("R5 R7 lower strobe lag 2", 24'h120030, 3'd5, 1'b1, 0, 1, 2, 5, 5, 2'b00, 0);
    optReg = mkOpt(2'b11, 2'b11, 1'b1, 4'd1, 2'b11, 3'd0, 1'b0);
    busCycle("R7 either strobe lag 4", 24'h120030, 3'd5, 1'b0, 1, 0, 4, 7, 9, 2'b00, 0);

    // R8 largest count, R10 external
    optReg = mkOpt(2'b11, 2'b11, 1'b0, 4'd13, 2'b11, 3'd0, 1'b0);
    busCycle("R8 thirteen waits", 24'h12FFFE, 3'd6, 1'b1, 1, 1, 0, 3, 17, 2'b00, 0);
    optReg = mkOpt(2'b11, 2'b11, 1'b0, 4'd15, 2'b11, 3'd0, 1'b0);
    busCycle("R10 external termination", 24'h120040, 3'd6, 1'b1, 1, 1, 0, 3, 0, 2'b11, 0);

    // R11 8-bit port
    pinMode = 2'b10;
    optReg = mkOpt(2'b11, 2'b11, 1'b0, 4'd3, 2'b11, 3'd0, 1'b0);
    busCycle("R11 8-bit port lanes", 24'h120050, 3'd5, 1'b1, 1, 1, 0, 3, 7, 2'b10, 0);
    pinMode = 2'b11;

    // R3/R13 CPU space, level 5 at address bits 3:1
    optReg = mkOpt(2'b11, 2'b11, 1'b0, 4'd14, 2'b00, 3'd5, 1'b1);
    busCycle("R13 autovector level 5", 24'h0F000A, 3'd7, 1'b1, 1, 1, 0, 3, 0, 2'b11, 3);
    busCycle("R3 level mismatch", 24'h0F0006, 3'd7, 1'b1, 1, 1, 0, 0, 0, 2'b11, 0);
    optReg = mkOpt(2'b11, 2'b11, 1'b0, 4'd14, 2'b00, 3'd0, 1'b0);
    busCycle("R3 any level plain ack", 24'h0F0006, 3'd7, 1'b1, 1, 1, 0, 3, 3, 2'b00, 0);

    // R12 discrete and alternate
    pinMode = 2'b00; discreteBit = 1'b1;
    optReg = mkOpt(2'b11, 2'b11, 1'b0, 4'd14, 2'b11, 3'd0, 1'b0);
    busCycle("R12 discrete ignores decode", 24'h120060, 3'd5, 1'b1, 1, 1, 0, 0, 0, 2'b11, 0);
    @(negedge clk); discreteBit = 1'b0;
    @(posedge clk); #1;
    check("R12 discrete low", int'(selN), 0);
    @(negedge clk); discreteBit = 1'b1;
    @(posedge clk); #1;
    check("R12 discrete high", int'(selN), 1);
    @(negedge clk); discreteBit = 1'b0; pinMode = 2'b01;
    @(posedge clk); #1;
    check("R12 alternate holds high", int'(selN), 1);
    busCycle("R12 alternate ignores decode", 24'h120060, 3'd5, 1'b1, 1, 1, 0, 0, 0, 2'b11, 0);

    repeat (4) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule